// File: doc/BRIEF.md
# Single-Wire Bus Master Controller

This block is a memory-mapped master for a serial bus made of one open-drain data line. Software loads a byte into a transmit register and then writes a control word. That word selects the direction, a break/reset sequence or a one-bit transfer, and sets a start bit. The controller runs the transfer on the line. When it finishes it clears the start bit and records the outcome as a sticky flag. A level interrupt output is raised when the flags are enabled.

The line is modelled as an output-enable that pulls the wire low, plus the wire's level, which is synchronized on entry. The master sets the timing of writes. Each written bit is a low pulse inside a fixed slot, and its length encodes the value. The slave sets the timing of reads. It pulls the line low to start each bit and holds it for a short or long time. The master samples a fixed number of cycles after it sees the falling edge. A second timing profile scales every duration down by a power of two. Every duration is a parameter in clock cycles.

The register port carries byte-wide data. Registers sit on word-aligned offsets, and reads are combinational.

Top module: `swb_master`

## Requirements
- R1: Byte offsets: 0x00 revision (read-only, major in bits 7:4, minor in bits 3:0, default 0x21); 0x04 transmit byte; 0x08 receive byte; 0x0C control; 0x10 event flags. After reset, every register except the revision reads 0 and the line is released.
- R2: Control bits: 7 one-bit mode, 6 interrupt enable, 5 clock enable, 4 start, 3 presence (read-only), 2 break, 1 direction (1 = read), 0 fast profile.
  - Writing start=1 with direction=0 sends the transmit byte least-significant bit first.
  - Each bit occupies a slot of SLOT_CYC cycles. The line is low for LOW1_CYC cycles for a 1 and LOW0_CYC cycles for a 0.
  - At the end the controller sets flag bit 2 (sent) and clears start.
- R3: Writing start=1 with direction=1 receives a byte least-significant bit first.
  - Each bit begins when the slave pulls the line low.
  - The line level SAMPLE_CYC cycles after that falling edge is detected is the bit value.
  - The byte lands in the receive register, and flag bit 1 (received) is set.
- R4: If a read sees no falling edge within RESP_CYC cycles, or the line stays low that long, the read stops. Flag bit 0 (timeout) is set and the receive register keeps its old value.
- R5: Writing break=1 with start=1 performs the break sequence:
  - presence is cleared first;
  - the line is pulled low for BREAK_CYC cycles;
  - the line is watched for PRES_CYC cycles, and presence is set if the slave pulls it low;
  - flag bit 0 is set, and break and start return to 0.
- R6: In one-bit mode, a write sends only bit 0 of the transmit byte. A read receives one bit into bit 0 of the receive register, with bits 7:1 reading 0.
- R7: With control bit 0 set, every duration is shifted right by FAST_SHIFT.
- R8: Reading the flags register returns the accumulated flags and clears them. The irq output is 1 exactly when interrupt enable is 1 and some flag is set.
- R9: A start request made while a transfer runs is ignored. The running transfer completes unchanged, and no second transfer follows.
- R10: While clock enable is 0, start cannot be set, the line stays released, and a running transfer is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags at 0x10) |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| irq | output | 1 | Level interrupt |
| line_oe | output | 1 | 1 pulls the bus line low |
| line_in | input | 1 | Bus line level, asynchronous |

## Verification
The bench measures the width of every low pulse the master drives, so a wrong bit order, a swapped pulse length or an unscaled fast profile shows up as a width mismatch. It acts as a slave that sends known bit patterns with long and short lows. A design that sampled too early or too late, or that mishandled one-bit mode, would store a different receive byte. A silent slave must produce the timeout flag with the receive register unchanged. A break with no answer must clear a presence bit left from the previous break. A start written mid-transfer, or written with the clock disabled, must launch nothing, and the bench treats any extra pulse on the line as an error.

// File: rtl/swb_pkg.sv
package swb_pkg;
    localparam int ADDR_W = 5;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = $clog2(BYTE_W);

    localparam logic [ADDR_W-1:0] OFS_REV  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_TX   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_RX   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CTL  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_FLAG = 5'h10;

    localparam int B_ONEBIT = 7;
    localparam int B_IRQEN  = 6;
    localparam int B_CLKEN  = 5;
    localparam int B_START  = 4;
    localparam int B_PRES   = 3;
    localparam int B_BREAK  = 2;
    localparam int B_READ   = 1;
    localparam int B_FAST   = 0;

    typedef enum logic [2:0] {
        ST_IDLE, ST_BRK_LOW, ST_BRK_LISTEN, ST_WR_LOW, ST_WR_REST,
        ST_RD_WAIT, ST_RD_SAMP, ST_RD_REL
    } eng_st_e;

    typedef struct packed {
        logic              brk;
        logic              read;
        logic              onebit;
        logic              fast;
        logic [BYTE_W-1:0] tx;
    } cmd_t;
endpackage

// File: rtl/swb_sync.sv
module swb_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/swb_regs.sv
module swb_regs
    import swb_pkg::*;
#(
    parameter logic [3:0] REV_MAJOR = 4'd2,
    parameter logic [3:0] REV_MINOR = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq,
    output logic              start_o,
    output cmd_t              cmd_o,
    output logic              enable_o,
    output logic              go_o,
    output logic              pres_o,
    input  logic              done_tx,
    input  logic              done_rx,
    input  logic              done_to,
    input  logic              pres_hit,
    input  logic [BYTE_W-1:0] rx_byte
);
    typedef struct packed {
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rx;
        logic              onebit;
        logic              irqen;
        logic              clken;
        logic              go;
        logic              pres;
        logic              brk;
        logic              read;
        logic              fast;
        logic [2:0]        flags;
    } regs_t;

    regs_t q, d;
    logic  wr_ctl, accept, any_done;

    always_comb begin
        d        = q;
        wr_ctl   = wr_en && (addr == OFS_CTL);
        accept   = wr_ctl && wdata[B_START] && wdata[B_CLKEN] && !q.go;
        any_done = done_tx || done_rx || done_to;

        if (wr_en && (addr == OFS_TX)) d.tx = wdata;
        if (wr_ctl) begin
            d.onebit = wdata[B_ONEBIT];
            d.irqen  = wdata[B_IRQEN];
            d.clken  = wdata[B_CLKEN];
            d.brk    = wdata[B_BREAK];
            d.read   = wdata[B_READ];
            d.fast   = wdata[B_FAST];
        end
        if (accept) begin
            d.go = 1'b1;
            if (wdata[B_BREAK]) d.pres = 1'b0;
        end
        if (pres_hit) d.pres = 1'b1;
        if (any_done) begin
            d.go  = 1'b0;
            d.brk = 1'b0;
        end
        if (done_rx) d.rx = rx_byte;
        if (!d.clken) d.go = 1'b0;

        d.flags = ((rd_en && (addr == OFS_FLAG)) ? 3'b000 : q.flags)
                  | {done_tx, done_rx, done_to};

        start_o     = accept;
        cmd_o.brk   = wdata[B_BREAK];
        cmd_o.read  = wdata[B_READ];
        cmd_o.onebit= wdata[B_ONEBIT];
        cmd_o.fast  = wdata[B_FAST];
        cmd_o.tx    = q.tx;
        enable_o    = d.clken;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (addr)
            OFS_REV:  rdata = {REV_MAJOR, REV_MINOR};
            OFS_TX:   rdata = q.tx;
            OFS_RX:   rdata = q.rx;
            OFS_CTL:  rdata = {q.onebit, q.irqen, q.clken, q.go,
                               q.pres, q.brk, q.read, q.fast};
            OFS_FLAG: rdata = {5'b0, q.flags};
            default:  rdata = '0;
        endcase
    end

    assign irq    = q.irqen && (q.flags != 3'b000);
    assign go_o   = q.go;
    assign pres_o = q.pres;
endmodule

// File: rtl/swb_engine.sv
module swb_engine
    import swb_pkg::*;
#(
    parameter int BREAK_CYC  = 40,
    parameter int PRES_CYC   = 30,
    parameter int SLOT_CYC   = 30,
    parameter int LOW1_CYC   = 5,
    parameter int LOW0_CYC   = 20,
    parameter int SAMPLE_CYC = 10,
    parameter int RESP_CYC   = 60,
    parameter int FAST_SHIFT = 1,
    parameter int GUARD_CYC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              start,
    input  cmd_t              cmd_i,
    input  logic              line_s,
    output logic              line_oe,
    output logic              done_tx,
    output logic              done_rx,
    output logic              done_to,
    output logic              pres_hit,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int CNT_W = $clog2(BREAK_CYC + PRES_CYC + SLOT_CYC + RESP_CYC + 1) + 1;
    localparam logic [CNT_W-1:0] ONE     = 1;
    localparam logic [CNT_W-1:0] GUARD_C = CNT_W'(GUARD_CYC);

    typedef struct packed {
        eng_st_e           st;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] sh;
        cmd_t              cmd;
    } eng_t;

    eng_t q, d;

    function automatic logic [CNT_W-1:0] scale(input logic fast, input int unsigned base);
        int unsigned v;
        v = fast ? (base >> FAST_SHIFT) : base;
        if (v == 0) v = 1;
        return v[CNT_W-1:0];
    endfunction

    logic [CNT_W-1:0] t_brk, t_pres, t_slot, t_low, t_samp, t_resp;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        t_brk    = scale(q.cmd.fast, BREAK_CYC);
        t_pres   = scale(q.cmd.fast, PRES_CYC);
        t_slot   = scale(q.cmd.fast, SLOT_CYC);
        t_low    = q.cmd.tx[q.idx] ? scale(q.cmd.fast, LOW1_CYC)
                                   : scale(q.cmd.fast, LOW0_CYC);
        t_samp   = scale(q.cmd.fast, SAMPLE_CYC);
        t_resp   = scale(q.cmd.fast, RESP_CYC);
        last_idx = q.cmd.onebit ? '0 : IDX_W'(BYTE_W - 1);

        d        = q;
        done_tx  = 1'b0;
        done_rx  = 1'b0;
        done_to  = 1'b0;
        pres_hit = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.cmd = cmd_i;
                    d.cnt = '0;
                    d.idx = '0;
                    d.sh  = '0;
                    if (cmd_i.brk)       d.st = ST_BRK_LOW;
                    else if (cmd_i.read) d.st = ST_RD_WAIT;
                    else                 d.st = ST_WR_LOW;
                end
            end
            ST_BRK_LOW: begin
                if (q.cnt == t_brk - ONE) begin
                    d.st  = ST_BRK_LISTEN;
                    d.cnt = '0;
                end else d.cnt = q.cnt + ONE;
            end
            ST_BRK_LISTEN: begin
                if (q.cnt >= GUARD_C && !line_s) pres_hit = 1'b1;
                if (q.cnt == t_pres - ONE) begin
                    done_to = 1'b1;
                    d.st    = ST_IDLE;
                end else d.cnt = q.cnt + ONE;
            end
            ST_WR_LOW: begin
                if (q.cnt == t_low - ONE) d.st = ST_WR_REST;
                d.cnt = q.cnt + ONE;
            end
            ST_WR_REST: begin
                if (q.cnt == t_slot - ONE) begin
                    if (q.idx == last_idx) begin
                        done_tx = 1'b1;
                        d.st    = ST_IDLE;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.cnt = '0;
                        d.st  = ST_WR_LOW;
                    end
                end else d.cnt = q.cnt + ONE;
            end
            ST_RD_WAIT: begin
                if (!line_s) begin
                    d.st  = ST_RD_SAMP;
                    d.cnt = '0;
                end else if (q.cnt == t_resp - ONE) begin
                    done_to = 1'b1;
                    d.st    = ST_IDLE;
                end else d.cnt = q.cnt + ONE;
            end
            ST_RD_SAMP: begin
                if (q.cnt == t_samp - ONE) begin
                    d.sh  = {line_s, q.sh[BYTE_W-1:1]};
                    d.cnt = '0;
                    d.st  = ST_RD_REL;
                end else d.cnt = q.cnt + ONE;
            end
            ST_RD_REL: begin
                if (line_s) begin
                    if (q.idx == last_idx) begin
                        done_rx = 1'b1;
                        d.st    = ST_IDLE;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.cnt = '0;
                        d.st  = ST_RD_WAIT;
                    end
                end else if (q.cnt == t_resp - ONE) begin
                    done_to = 1'b1;
                    d.st    = ST_IDLE;
                end else d.cnt = q.cnt + ONE;
            end
            default: d.st = ST_IDLE;
        endcase

        if (!enable) begin
            d.st     = ST_IDLE;
            done_tx  = 1'b0;
            done_rx  = 1'b0;
            done_to  = 1'b0;
            pres_hit = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign line_oe = (q.st == ST_BRK_LOW) || (q.st == ST_WR_LOW);
    assign rx_byte = q.cmd.onebit ? {{(BYTE_W-1){1'b0}}, q.sh[BYTE_W-1]} : q.sh;
endmodule

// File: rtl/swb_master.sv
module swb_master
    import swb_pkg::*;
#(
    parameter int         BREAK_CYC  = 40,
    parameter int         PRES_CYC   = 30,
    parameter int         SLOT_CYC   = 30,
    parameter int         LOW1_CYC   = 5,
    parameter int         LOW0_CYC   = 20,
    parameter int         SAMPLE_CYC = 10,
    parameter int         RESP_CYC   = 60,
    parameter int         FAST_SHIFT = 1,
    parameter int         SYNC_STG   = 2,
    parameter logic [3:0] REV_MAJOR  = 4'd2,
    parameter logic [3:0] REV_MINOR  = 4'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq,
    output logic              line_oe,
    input  logic              line_in
);
    localparam int GUARD_CYC = SYNC_STG + 1;

    logic              line_s, eng_start, eng_enable, ctl_go, ctl_pres;
    logic              done_tx, done_rx, done_to, pres_hit;
    logic [BYTE_W-1:0] rx_byte;
    cmd_t              eng_cmd;

    swb_sync #(.STAGES(SYNC_STG), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(line_in), .sync_o(line_s)
    );

    swb_regs #(.REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .start_o(eng_start),
        .cmd_o(eng_cmd), .enable_o(eng_enable), .go_o(ctl_go), .pres_o(ctl_pres),
        .done_tx(done_tx), .done_rx(done_rx), .done_to(done_to),
        .pres_hit(pres_hit), .rx_byte(rx_byte)
    );

    swb_engine #(
        .BREAK_CYC(BREAK_CYC), .PRES_CYC(PRES_CYC), .SLOT_CYC(SLOT_CYC),
        .LOW1_CYC(LOW1_CYC), .LOW0_CYC(LOW0_CYC), .SAMPLE_CYC(SAMPLE_CYC),
        .RESP_CYC(RESP_CYC), .FAST_SHIFT(FAST_SHIFT), .GUARD_CYC(GUARD_CYC)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .enable(eng_enable), .start(eng_start),
        .cmd_i(eng_cmd), .line_s(line_s), .line_oe(line_oe),
        .done_tx(done_tx), .done_rx(done_rx), .done_to(done_to),
        .pres_hit(pres_hit), .rx_byte(rx_byte)
    );
endmodule

// File: rtl/swb_master_chk.sv
module swb_master_chk
    import swb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic              irq,
    input logic              line_oe,
    input logic              ctl_go,
    input logic              eng_enable,
    input logic              eng_start,
    input logic              start_brk,
    input logic              ctl_pres,
    input logic              done_tx,
    input logic              done_rx,
    input logic              done_to
);
    AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == OFS_FLAG && !(done_tx || done_rx || done_to)) |=> !irq); // R8

    AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_go && eng_enable && !(done_tx || done_rx || done_to)) |=> ctl_go); // R9

    AST_LINE_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_go |-> !line_oe); // R10

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_tx, done_rx, done_to})); // R2

    AST_PRES_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start && start_brk) |=> !ctl_pres); // R5
endmodule

bind swb_master swb_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .irq(irq),
    .line_oe(line_oe), .ctl_go(ctl_go), .eng_enable(eng_enable),
    .eng_start(eng_start), .start_brk(eng_cmd.brk), .ctl_pres(ctl_pres),
    .done_tx(done_tx), .done_rx(done_rx), .done_to(done_to)
);

// File: tb/swb_master_tb.sv
`timescale 1ns/1ps
module swb_master_tb;
    localparam int BRK = 40, PRES = 30, SLOT = 30, L1 = 5, L0 = 20, SAMP = 10, RESP = 60, FSH = 1;
    localparam logic [4:0] A_REV = 5'h00, A_TX = 5'h04, A_RX = 5'h08, A_CTL = 5'h0C, A_FLG = 5'h10;

    logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, slave_pull = 0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic irq, line_oe, line;

    int checks = 0, failures = 0;
    bit finished = 0;

    typedef struct { int w; string tag; } exp_t;
    exp_t expq[$];

    always #5 clk = ~clk;
    assign line = !(line_oe || slave_pull);

    swb_master #(.BREAK_CYC(BRK), .PRES_CYC(PRES), .SLOT_CYC(SLOT), .LOW1_CYC(L1),
                 .LOW0_CYC(L0), .SAMPLE_CYC(SAMP), .RESP_CYC(RESP), .FAST_SHIFT(FSH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .line_oe(line_oe), .line_in(line)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int sc(input bit fast, input int v);
        return fast ? (v >> FSH) : v;
    endfunction

    function automatic logic [7:0] cv(input bit onebit, input bit irqen, input bit go,
                                      input bit brk, input bit rd, input bit fast);
        return {onebit, irqen, 1'b1, go, 1'b0, brk, rd, fast};
    endfunction

    // monitor: measures each low pulse driven by the master
    int width = 0;
    always @(negedge clk) begin
        if (line_oe) width++;
        else if (width != 0) begin
            if (expq.size() == 0) chk("R9 unexpected pulse width", width, 0);
            else begin
                exp_t e;
                e = expq.pop_front();
                chk(e.tag, width, e.w);
            end
            width = 0;
        end
    end

    task automatic push_bits(input logic [7:0] b, input int n, input bit fast, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.w = b[i] ? sc(fast, L1) : sc(fast, L0);
            e.tag = tag;
            expq.push_back(e);
        end
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [7:0] v);
        @(negedge clk); addr = a; wdata = v; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1; #1 v = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 3000; i++) begin
            bus_rd(A_CTL, v);
            if (!v[4]) break;
        end
    endtask

    task automatic slave_bits(input logic [7:0] b, input int n, input bit fast);
        int s;
        s = sc(fast, SAMP);
        repeat (8) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            int lo;
            lo = b[i] ? 2 : 2 * s + 4;
            slave_pull = 1;
            repeat (lo) @(negedge clk);
            slave_pull = 0;
            repeat (3 * s + 12 - lo) @(negedge clk);
        end
    endtask

    task automatic slave_presence();
        while (!line_oe) @(negedge clk);
        while (line_oe) @(negedge clk);
        repeat (5) @(negedge clk);
        slave_pull = 1;
        repeat (8) @(negedge clk);
        slave_pull = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        exp_t e;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state and map
        bus_rd(A_REV, v); chk("R1 revision", v, 8'h21);
        bus_rd(A_CTL, v); chk("R1 control reset", v, 0);
        bus_rd(A_RX, v);  chk("R1 rx reset", v, 0);
        chk("R1 line released", line_oe, 0);
        chk("R1 irq low", irq, 0);
        bus_wr(A_CTL, 8'h20);

        // R2 byte write
        bus_wr(A_TX, 8'hA5);
        push_bits(8'hA5, 8, 0, "R2 write pulse");
        bus_wr(A_CTL, cv(0, 0, 1, 0, 0, 0));
        wait_idle();
        bus_rd(A_FLG, v); chk("R2 sent flag", v, 8'h04);
        bus_rd(A_CTL, v); chk("R2 start cleared", v[4], 0);
        chk("R2 all pulses seen", expq.size(), 0);

        // R7 fast write
        bus_wr(A_TX, 8'h3C);
        push_bits(8'h3C, 8, 1, "R7 fast write pulse");
        bus_wr(A_CTL, cv(0, 0, 1, 0, 0, 1));
        wait_idle();
        bus_rd(A_FLG, v); chk("R7 sent flag", v, 8'h04);

        // R6 one-bit write
        bus_wr(A_TX, 8'hFE);
        push_bits(8'hFE, 1, 0, "R6 one-bit write pulse");
        bus_wr(A_CTL, cv(1, 0, 1, 0, 0, 0));
        wait_idle();
        repeat (40) @(negedge clk);
        chk("R6 one pulse only", expq.size(), 0);
        bus_rd(A_FLG, v); chk("R6 sent flag", v, 8'h04);

        // R3 byte read
        fork
            slave_bits(8'h5A, 8, 0);
            bus_wr(A_CTL, cv(0, 0, 1, 0, 1, 0));
        join
        wait_idle();
        bus_rd(A_RX, v);  chk("R3 rx byte", v, 8'h5A);
        bus_rd(A_FLG, v); chk("R3 received flag", v, 8'h02);

        // R7 fast read
        fork
            slave_bits(8'hC3, 8, 1);
            bus_wr(A_CTL, cv(0, 0, 1, 0, 1, 1));
        join
        wait_idle();
        bus_rd(A_RX, v); chk("R7 fast rx byte", v, 8'hC3);
        bus_rd(A_FLG, v);

        // R6 one-bit read
        fork
            slave_bits(8'h01, 1, 0);
            bus_wr(A_CTL, cv(1, 0, 1, 0, 1, 0));
        join
        wait_idle();
        bus_rd(A_RX, v);  chk("R6 one-bit rx", v, 8'h01);
        bus_rd(A_FLG, v); chk("R6 received flag", v, 8'h02);

        // R4 no response
        bus_wr(A_CTL, cv(0, 0, 1, 0, 1, 0));
        wait_idle();
        bus_rd(A_FLG, v); chk("R4 timeout flag", v, 8'h01);
        bus_rd(A_RX, v);  chk("R4 rx unchanged", v, 8'h01);

        // R5 break with presence
        e.w = BRK; e.tag = "R5 break width"; expq.push_back(e);
        fork
            slave_presence();
            bus_wr(A_CTL, cv(0, 0, 1, 1, 0, 0));
        join
        wait_idle();
        bus_rd(A_FLG, v); chk("R5 break done flag", v, 8'h01);
        bus_rd(A_CTL, v); chk("R5 presence set", v[3], 1);
        chk("R5 break bit cleared", v[2], 0);
        chk("R5 start cleared", v[4], 0);

        // R5 break without presence
        e.w = BRK; e.tag = "R5 break width"; expq.push_back(e);
        bus_wr(A_CTL, cv(0, 0, 1, 1, 0, 0));
        wait_idle();
        bus_rd(A_CTL, v); chk("R5 presence cleared", v[3], 0);
        bus_rd(A_FLG, v);

        // R8 interrupt
        bus_wr(A_TX, 8'h81);
        push_bits(8'h81, 8, 0, "R8 write pulse");
        bus_wr(A_CTL, cv(0, 1, 1, 0, 0, 0));
        wait_idle();
        chk("R8 irq raised", irq, 1);
        bus_rd(A_FLG, v); chk("R8 flags read", v, 8'h04);
        chk("R8 irq cleared", irq, 0);
        bus_rd(A_FLG, v); chk("R8 flags cleared", v, 0);
        bus_wr(A_TX, 8'h0F);
        push_bits(8'h0F, 8, 0, "R8 write pulse");
        bus_wr(A_CTL, cv(0, 0, 1, 0, 0, 0));
        wait_idle();
        chk("R8 irq masked", irq, 0);
        bus_rd(A_FLG, v); chk("R8 masked flags", v, 8'h04);

        // R9 start while busy
        bus_wr(A_TX, 8'h66);
        push_bits(8'h66, 8, 0, "R9 write pulse");
        bus_wr(A_CTL, cv(0, 0, 1, 0, 0, 0));
        repeat (70) @(negedge clk);
        bus_wr(A_CTL, cv(0, 0, 1, 0, 1, 0));
        wait_idle();
        repeat (150) @(negedge clk);
        bus_rd(A_FLG, v); chk("R9 only sent flag", v, 8'h04);
        chk("R9 no extra pulses", expq.size(), 0);

        // R10 clock disabled
        bus_wr(A_CTL, 8'h10);
        repeat (100) @(negedge clk);
        bus_rd(A_CTL, v); chk("R10 start refused", v[4], 0);
        bus_rd(A_FLG, v); chk("R10 no flags", v, 0);
        chk("R10 line released", line_oe, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule